// File: doc/BRIEF.md
# Vandermonde Parity Encoder over GF(2^8)

This block produces the redundancy bytes of a systematic erasure code. A stripe is cut into `DATA_CHUNKS` data chunks. For each byte position, the caller streams the data bytes of that position into the block, one byte per handshake. Each byte is tagged with the number of the chunk it came from. The data bytes themselves are stored unchanged by the caller. The block returns only the `PARITY_ROWS` check bytes.

Check row `i` (counting from 0) is a weighted sum over the data bytes. The weight of the byte from chunk tag `t` is `(t+1)` raised to the power `i`. Addition is XOR. Multiplication is carry-less with reduction by x^8+x^4+x^3+x^2+1, which is 0x11D. Row 0 is therefore the plain XOR of the data bytes.

The weights are never stored. When a byte arrives, it is added into row 0 as it is. It is then multiplied by its column number again and again, once per further row, and each product is added into the next row's accumulator. Each multiply is a shift-and-reduce loop over the bits of the column number.

The control is a three-state machine:
- **IDLE**: `in_ready` is high.
  - IDLE → MUL on an accepted byte when there is more than one check row.
  - IDLE → DRAIN on the last byte of a position when there is only one check row.
- **MUL**: multiplies for rows 1 to `PARITY_ROWS-1` run here.
  - MUL → MUL while rows remain.
  - MUL → IDLE after the final row of a byte that did not complete the position.
  - MUL → DRAIN after the final row of the byte that completed it.
- **DRAIN**: presents one check byte per cycle.
  - DRAIN → IDLE after row `PARITY_ROWS-1`.

Top module: `rse_vander_enc`

## Requirements
- R1: After reset, `in_ready` is 1 and `par_valid` is 0.
- R2: Check row 0 equals the XOR of the `DATA_CHUNKS` data bytes of the position.
- R3: Check row `i` equals the XOR, over all data bytes `d` with tag `t`, of `(t+1)^i · d`. The arithmetic is GF(2^8) with reduction polynomial 0x11D. The tag `in_idx` is a binary chunk number in `0 .. DATA_CHUNKS-1`.
- R4: The data bytes of a position may arrive in any order of tags, and the check bytes do not depend on that order.
- R5: The accumulators restart at the first byte of every position, so a position's check bytes do not depend on earlier positions.
- R6: Once the last data byte of a position has been processed, the `PARITY_ROWS` check bytes appear on consecutive cycles with `par_valid` high, row 0 first and in ascending row order.
- R7: `par_last` is 1 exactly with the byte of row `PARITY_ROWS-1`.
- R8: `in_ready` is 0 from the cycle after an accepted byte until that byte's multiplies are done, and throughout DRAIN. It is 1 again on the cycle after the final check byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Block can take a data byte |
| in_data | input | 8 | Data byte |
| in_idx | input | IW | Chunk tag of the data byte, 0 .. DATA_CHUNKS-1 |
| par_valid | output | 1 | Check byte present |
| par_data | output | 8 | Check byte |
| par_last | output | 1 | Check byte is the final row |

## Verification
The corner cases the bench goes after are these:
- **Reduction.** A data byte of 0x80, or of all ones, in the highest column forces the modular doubling to reduce. A multiplier that tests the overflow bit after the shift, or that uses the wrong polynomial, returns wrong bytes for rows 1 and up.
- **Position boundaries.** An all-zero position straight after a busy one must give all-zero checks. An accumulator that is not cleared at the first byte leaks the previous position into it.
- **Arrival order.** The same bytes are sent in forward, reverse and shuffled order. A design that derives the column from arrival order instead of the tag gives results that differ between runs.
- **Output stream.** The bench checks for gaps in the output burst, a misplaced last flag, and ready being raised during drain. A wrong burst or a wrong flag shows up as row misalignment, and an early ready shows up as a byte accepted while the checks are still being emitted.

// File: rtl/rse_pkg.sv
package rse_pkg;

    localparam logic [7:0] GF_REDUCE = 8'h1D;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MUL   = 2'd1,
        ST_DRAIN = 2'd2
    } enc_state_t;

    // Multiply by x modulo x^8+x^4+x^3+x^2+1: overflow tested on bit 7 before the shift.
    function automatic logic [7:0] gf_xtime(input logic [7:0] v);
        return v[7] ? ({v[6:0], 1'b0} ^ GF_REDUCE) : {v[6:0], 1'b0};
    endfunction

endpackage

// File: rtl/rse_gf_mul_iter.sv
module rse_gf_mul_iter
    import rse_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] mcand_i,
    input  logic [7:0] mplier_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] prod_o
);

    logic [7:0] mc_q, mp_q, pr_q;
    logic       busy_q, done_q;
    logic [7:0] pr_next;

    always_comb begin
        pr_next = pr_q ^ (mp_q[0] ? mc_q : 8'h00);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_q   <= '0;
            mp_q   <= '0;
            pr_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                mc_q   <= mcand_i;
                mp_q   <= mplier_i;
                pr_q   <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                pr_q <= pr_next;
                mc_q <= gf_xtime(mc_q);
                mp_q <= {1'b0, mp_q[7:1]};
                if (mp_q[7:1] == 7'd0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign prod_o = pr_q;

    AST_START_WHILE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R8
    AST_START_LEADS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q); // R3
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q); // R3

endmodule

// File: rtl/rse_acc_bank.sv
module rse_acc_bank #(
    parameter int ROWS = 2,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 we,
    input  logic [RW-1:0]        waddr,
    input  logic [7:0]           wdata,
    output logic [ROWS-1:0][7:0] acc_o
);

    logic [7:0] acc_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [7:0] base;
        logic       hit;
        always_comb begin
            base = clr ? 8'h00 : acc_q[r];
            hit  = we && (waddr == RW'(r));
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) acc_q[r] <= '0;
            else        acc_q[r] <= base ^ (hit ? wdata : 8'h00);
        end
        assign acc_o[r] = acc_q[r];

        if (r > 0) begin : g_clr_chk
            AST_ROW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> (acc_q[r] == 8'h00)); // R5
        end
    end

endmodule

// File: rtl/rse_vander_enc.sv
module rse_vander_enc
    import rse_pkg::*;
#(
    parameter int DATA_CHUNKS = 4,
    parameter int PARITY_ROWS = 2,
    localparam int IW = (DATA_CHUNKS > 1) ? $clog2(DATA_CHUNKS) : 1,
    localparam int RW = (PARITY_ROWS > 1) ? $clog2(PARITY_ROWS) : 1,
    localparam int CW = $clog2(DATA_CHUNKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic [IW-1:0] in_idx,
    output logic          par_valid,
    output logic [7:0]    par_data,
    output logic          par_last
);

    localparam logic [RW-1:0] LAST_ROW = RW'(PARITY_ROWS - 1);

    enc_state_t state_q, state_d;
    logic [7:0]    col_q;
    logic [RW-1:0] row_q;
    logic [CW-1:0] cnt_q;
    logic          fin_q;

    logic       accept, final_byte;
    logic [7:0] col_next;
    logic       mul_start, mul_busy, mul_done;
    logic [7:0] mul_a, mul_b, mul_prod;
    logic       acc_clr, acc_we;
    logic [RW-1:0] acc_waddr;
    logic [7:0] acc_wdata;
    logic [PARITY_ROWS-1:0][7:0] acc_rows;

    assign accept     = in_valid && (state_q == ST_IDLE);
    assign final_byte = (cnt_q == CW'(DATA_CHUNKS - 1));
    assign col_next   = 8'(in_idx) + 8'd1;

    // Next-state and datapath control
    always_comb begin
        state_d   = state_q;
        mul_start = 1'b0;
        mul_a     = mul_prod;
        mul_b     = col_q;
        acc_clr   = 1'b0;
        acc_we    = 1'b0;
        acc_waddr = row_q;
        acc_wdata = mul_prod;
        unique case (state_q)
            ST_IDLE: begin
                mul_a     = in_data;
                mul_b     = col_next;
                acc_waddr = '0;
                acc_wdata = in_data;
                if (accept) begin
                    acc_we  = 1'b1;
                    acc_clr = (cnt_q == '0);
                    if (PARITY_ROWS > 1) begin
                        mul_start = 1'b1;
                        state_d   = ST_MUL;
                    end else if (final_byte) begin
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_MUL: begin
                if (mul_done) begin
                    acc_we = 1'b1;
                    if (row_q == LAST_ROW) state_d = fin_q ? ST_DRAIN : ST_IDLE;
                    else                   mul_start = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (row_q == LAST_ROW) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Position and row bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= 8'd1;
            row_q <= '0;
            cnt_q <= '0;
            fin_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    col_q <= col_next;
                    row_q <= (PARITY_ROWS > 1) ? RW'(1) : '0;
                    fin_q <= final_byte;
                    cnt_q <= final_byte ? '0 : cnt_q + CW'(1);
                end
                ST_MUL: if (mul_done) begin
                    row_q <= (row_q == LAST_ROW) ? '0 : row_q + RW'(1);
                end
                ST_DRAIN: row_q <= (row_q == LAST_ROW) ? '0 : row_q + RW'(1);
                default: row_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        par_valid = (state_q == ST_DRAIN);
        par_data  = acc_rows[row_q];
        par_last  = (state_q == ST_DRAIN) && (row_q == LAST_ROW);
    end

    rse_gf_mul_iter u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (mul_start),
        .mcand_i  (mul_a),
        .mplier_i (mul_b),
        .busy_o   (mul_busy),
        .done_o   (mul_done),
        .prod_o   (mul_prod)
    );

    rse_acc_bank #(.ROWS(PARITY_ROWS)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .we    (acc_we),
        .waddr (acc_waddr),
        .wdata (acc_wdata),
        .acc_o (acc_rows)
    );

    AST_TAG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (32'(in_idx) < DATA_CHUNKS)); // R3
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (PARITY_ROWS > 1)) |=> !in_ready); // R8
    AST_BURST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && !par_last) |=> par_valid); // R6
    AST_LAST_CLOSES_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && par_last) |=> (!par_valid && in_ready)); // R7
    AST_MUL_ONLY_IN_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        mul_busy |-> (state_q == ST_MUL)); // R8

endmodule

// File: tb/sim_rse_vander_enc.sv
module sim_rse_vander_enc;

    localparam int K  = 4;
    localparam int M  = 2;
    localparam int IW = (K > 1) ? $clog2(K) : 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic [IW-1:0] in_idx = '0;
    logic          par_valid;
    logic [7:0]    par_data;
    logic          par_last;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] rx_data [64];
    bit         rx_last [64];
    int         rx_cnt = 0;
    bit         prev_v = 1'b0;
    bit         prev_l = 1'b0;

    logic [7:0] pos_d   [K];
    int         pos_ord [K];
    logic [7:0] got_par [M];
    logic [7:0] ref_par [M];

    always #4 clk = ~clk;

    rse_vander_enc #(.DATA_CHUNKS(K), .PARITY_ROWS(M)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_idx(in_idx), .par_valid(par_valid),
        .par_data(par_data), .par_last(par_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int t = 0; t < 8; t++) if (b[t]) p ^= (16'(a) << t);
        for (int t = 15; t >= 8; t--) if (p[t]) p ^= (16'h11D << (t - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] ref_pow(input logic [7:0] base, input int e);
        logic [7:0] r = 8'd1;
        for (int t = 0; t < e; t++) r = ref_mul(r, base);
        return r;
    endfunction

    // Output collector
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v && !prev_l) check(par_valid, "R6 burst gap", 32'(par_valid), 1);
            if (par_valid) begin
                check(!in_ready, "R8 ready during drain", 32'(in_ready), 0);
                rx_data[rx_cnt & 63] = par_data;
                rx_last[rx_cnt & 63] = par_last;
                rx_cnt++;
            end
            prev_v = par_valid;
            prev_l = par_last;
        end
    end

    // Called at a negedge
    task automatic send_byte(input int idx, input logic [7:0] d);
        in_valid = 1'b1;
        in_idx   = IW'(idx);
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hA5;
        check(!in_ready, "R8 busy after accept", 32'(in_ready), 0);
    endtask

    task automatic run_pos(input string req);
        int base = rx_cnt;
        for (int r = 0; r < M; r++) ref_par[r] = 8'h00;
        for (int j = 0; j < K; j++)
            for (int r = 0; r < M; r++)
                ref_par[r] ^= ref_mul(ref_pow(8'(j + 1), r), pos_d[j]);
        for (int n = 0; n < K; n++) send_byte(pos_ord[n], pos_d[pos_ord[n]]);
        wait (rx_cnt >= base + M);
        @(negedge clk);
        check(in_ready, "R8 ready after drain", 32'(in_ready), 1);
        for (int r = 0; r < M; r++) begin
            got_par[r] = rx_data[(base + r) & 63];
            check(got_par[r] == ref_par[r], (r == 0) ? {"R2 ", req} : {"R3 ", req},
                  32'(got_par[r]), 32'(ref_par[r]));
            check(rx_last[(base + r) & 63] == (r == M - 1), "R7 last flag",
                  32'(rx_last[(base + r) & 63]), 32'(r == M - 1));
        end
    endtask

    task automatic order_fwd();
        for (int n = 0; n < K; n++) pos_ord[n] = n;
    endtask

    task automatic order_shuffle();
        order_fwd();
        for (int n = K - 1; n > 0; n--) begin
            int s = int'($urandom_range(n, 0));
            int tmp = pos_ord[n];
            pos_ord[n] = pos_ord[s];
            pos_ord[s] = tmp;
        end
    endtask

    initial begin
        logic [7:0] first_par [M];
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready, "R1 ready after reset", 32'(in_ready), 1);
        check(!par_valid, "R1 no output after reset", 32'(par_valid), 0);

        // Single byte with top bit set in the highest column: reduction path
        for (int j = 0; j < K; j++) pos_d[j] = 8'h00;
        pos_d[K - 1] = 8'h80;
        order_fwd();
        run_pos("reduce 0x80");

        // All ones
        for (int j = 0; j < K; j++) pos_d[j] = 8'hFF;
        order_fwd();
        run_pos("all ones");

        // All zero right after a nonzero position: R5 restart
        for (int j = 0; j < K; j++) pos_d[j] = 8'h00;
        order_fwd();
        run_pos("R5 zero after busy");
        for (int r = 0; r < M; r++)
            check(got_par[r] == 8'h00, "R5 cleared", 32'(got_par[r]), 0);

        // Same bytes, forward then reverse order: R4
        for (int j = 0; j < K; j++) pos_d[j] = 8'(8'h3C + 8'(j * 37));
        order_fwd();
        run_pos("R4 forward");
        for (int r = 0; r < M; r++) first_par[r] = got_par[r];
        for (int n = 0; n < K; n++) pos_ord[n] = K - 1 - n;
        run_pos("R4 reverse");
        for (int r = 0; r < M; r++)
            check(got_par[r] == first_par[r], "R4 order independent",
                  32'(got_par[r]), 32'(first_par[r]));

        // Random positions with shuffled arrival
        for (int p = 0; p < 40; p++) begin
            for (int j = 0; j < K; j++) pos_d[j] = 8'($urandom);
            order_shuffle();
            run_pos("R4 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule